// File: doc/BRIEF.md
# E1 Non-Alignment Frame Spare-Bit Composer

This block works out the overhead bits of E1 time slot 0 that the transmit framer places in each frame without the alignment word (the odd frames of a 16-frame CRC-4 multiframe). For each such frame it gives the E bit that goes into bit 1 of frames 13 and 15, the remote alarm A bit in bit 3, and the five national bits Sa4 to Sa8 in bits 4 to 8. The frame timing comes in as a one-cycle start strobe together with the number of the frame that is about to go out. The receive framer's status arrives as live levels and pulses. The configuration arrives as plain register fields.

Software can force the A bit, or let any chosen receive alarm force it. E bits can be written as static values, requested one at a time as single-shot zeros, produced automatically from errored submultiframe reports, or held at zero while CRC-4 multiframe alignment is lost. When more than one of these is active, a zero from any of them wins. The Sa bits come from a register, from an external or internal serial data link, or from a transmit stack. All configuration is copied into a shadow set only at the start of frame 0, so a multiframe is never sent with mixed settings.

Top module: `e1nf_composer`

## Requirements
- R1: After reset, tx_e_bit is 1, tx_a_bit is 0 and tx_sa is 5'b11111. The outputs change only in the cycle after a frame start whose frame number is odd. They hold their value through frame starts with an even number and between frame starts.
- R2: With no enabled alarm condition active, tx_a_bit is 0 in every odd frame. When the shadowed cfg_a_force is 1, tx_a_bit is 1.
- R3: cfg_a_en bit k lets condition k force tx_a_bit to 1. The conditions are: bit 0 loss of frame alignment (rx_lfa), bit 1 loss of CRC-4 multiframe alignment (rx_lmfa), bit 2 loss of slot-16 signalling multiframe (rx_lsmfa), bit 3 CRC-4 multiframe loss after timer expiry (rx_lmfa_timed), bit 4 Sa6 pattern 8h seen (rx_sa6_8h), and bit 5 Sa6 pattern Ch seen (rx_sa6_ch). A condition with its enable bit at 0 has no effect.
- R4: tx_e_bit is 1 in every odd frame other than 13 and 15. In frames 13 and 15 it is also 1 when no E-bit source calls for a 0.
- R5: With cfg_e_single at 0 (static mode), cfg_e13_val gives the frame-13 E bit and cfg_e15_val gives the frame-15 E bit.
- R6: With cfg_e_single at 1 (single-shot mode), a one-cycle pulse on sw_e13_clr (or sw_e15_clr) produces exactly one 0 in the next frame 13 (or frame 15), and the E bit returns to 1 after that. Pulses that arrive in static mode are discarded.
- R7: With cfg_e_auto at 1, each rx_smf_err pulse yields one 0 E bit. The frame-13 E bit is used when rx_smf_id is 0 (submultiframe I), and the frame-15 E bit when rx_smf_id is 1 (submultiframe II). Up to 3 reports per slot are queued, and further reports are dropped.
- R8: With cfg_e_lmfa_hold at 1, both E bits are 0 whenever rx_lmfa is 1 at the frame start.
- R9: With cfg_e_timed_hold at 1, both E bits are 0 whenever rx_lmfa_timed is 1 at the frame start.
- R10: When several E-bit sources are active at once, the E bit is the AND of their values.
- R11: The Sa bits are mapped as tx_sa[0]=Sa4 through tx_sa[4]=Sa8. cfg_sa_mode selects the source. Mode 0 sends cfg_sa_reg. Mode 1 sends ext_dl on Sa4 and cfg_sa_reg[4:1] on Sa5 to Sa8. Mode 2 does the same with hdlc_dl in place of ext_dl. Mode 3 sends stack_word. The serial and stack inputs are sampled at the frame start.
- R12: Changes to the cfg_* inputs take effect only from the next frame start with frame number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | One-cycle strobe at the start of a frame |
| frm_num | input | 4 | Multiframe position (0-15) of the starting frame |
| rx_lfa | input | 1 | Receive loss of basic frame alignment |
| rx_lmfa | input | 1 | Receive loss of CRC-4 multiframe alignment |
| rx_lmfa_timed | input | 1 | CRC-4 multiframe loss lasting past the 100/400 ms timer |
| rx_lsmfa | input | 1 | Loss of slot-16 signalling multiframe alignment |
| rx_sa6_8h | input | 1 | Sa6 pattern 8h being received |
| rx_sa6_ch | input | 1 | Sa6 pattern Ch being received |
| rx_smf_err | input | 1 | One-cycle pulse: errored CRC-4 submultiframe received |
| rx_smf_id | input | 1 | Submultiframe of the error (0 = I, 1 = II) |
| cfg_a_force | input | 1 | Software alarm: force A bit to 1 |
| cfg_a_en | input | 6 | Per-condition enables for A-bit forcing |
| cfg_e_single | input | 1 | E manual mode: 0 static, 1 single-shot |
| cfg_e13_val | input | 1 | Static frame-13 E value |
| cfg_e15_val | input | 1 | Static frame-15 E value |
| sw_e13_clr | input | 1 | Pulse: software wrote 0 to the frame-13 control |
| sw_e15_clr | input | 1 | Pulse: software wrote 0 to the frame-15 control |
| cfg_e_auto | input | 1 | Enable automatic E bits from errored submultiframes |
| cfg_e_lmfa_hold | input | 1 | Hold E bits at 0 during multiframe loss |
| cfg_e_timed_hold | input | 1 | Hold E bits at 0 during timed multiframe loss |
| cfg_sa_mode | input | 2 | Sa source select |
| cfg_sa_reg | input | 5 | Sa register value (bit 0 = Sa4) |
| ext_dl | input | 1 | External serial data link bit |
| hdlc_dl | input | 1 | Internal HDLC serial bit |
| stack_word | input | 5 | Transmit stack Sa word (bit 0 = Sa4) |
| tx_e_bit | output | 1 | E bit for bit 1 of the current odd frame |
| tx_a_bit | output | 1 | Remote alarm A bit (bit 3) |
| tx_sa | output | 5 | Sa4 to Sa8 (bits 4 to 8) |

## Verification
Every output is registered once. The A, E and Sa values for a frame are due on the clock edge that samples its frm_start, so the bench drives each strobe for one cycle starting at a falling edge and reads the outputs at the next falling edge. Configuration changes are registered at a frame-0 start, so each scenario applies its settings first and then runs a whole multiframe. Only the odd frames of that multiframe are checked against the new settings. Single-shot and error pulses are given between frame strobes, and their effect is expected in the next frame 13 or 15, or in later multiframes when queued.

// File: rtl/e1nf_pkg.sv
package e1nf_pkg;

  localparam int unsigned FRAMES_PER_MF = 16;
  localparam int unsigned FRM_W         = $clog2(FRAMES_PER_MF);
  localparam int unsigned SA_W          = 5;
  localparam int unsigned N_ACOND       = 6;
  localparam int unsigned N_ESLOT       = 2;

  // Alarm condition positions inside the enable / condition vectors
  localparam int unsigned AC_LFA      = 0;
  localparam int unsigned AC_LMFA     = 1;
  localparam int unsigned AC_LSMFA    = 2;
  localparam int unsigned AC_LMFA_TMR = 3;
  localparam int unsigned AC_SA6_8    = 4;
  localparam int unsigned AC_SA6_C    = 5;

  typedef enum logic [1:0] {
    SA_REG   = 2'd0,
    SA_EXT   = 2'd1,
    SA_HDLC  = 2'd2,
    SA_STACK = 2'd3
  } sa_mode_e;

  typedef struct packed {
    logic                a_force;
    logic [N_ACOND-1:0]  a_en;
    logic                e_single;
    logic [N_ESLOT-1:0]  e_static;
    logic                e_auto;
    logic                e_hold;
    logic                e_hold_tmr;
    sa_mode_e            sa_mode;
    logic [SA_W-1:0]     sa_reg;
  } cfg_t;

endpackage

// File: rtl/e1nf_alarm.sv
module e1nf_alarm
  import e1nf_pkg::*;
(
  input  logic               force_i,
  input  logic [N_ACOND-1:0] en_i,
  input  logic [N_ACOND-1:0] cond_i,
  output logic               a_o
);

  logic [N_ACOND-1:0] armed;

  always_comb begin
    for (int k = 0; k < N_ACOND; k++) begin
      armed[k] = en_i[k] & cond_i[k];
    end
    a_o = force_i | (|armed);
  end

endmodule

// File: rtl/e1nf_eslot.sv
module e1nf_eslot
  import e1nf_pkg::*;
#(
  parameter int unsigned CNT_W      = 2,
  parameter int unsigned SLOT_FRAME = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_start,
  input  logic [FRM_W-1:0] frm_num,
  input  logic single_i,
  input  logic static_i,
  input  logic auto_i,
  input  logic hold_i,
  input  logic shot_i,
  input  logic err_i,
  output logic hit_o,
  output logic e_o
);

  localparam logic [FRM_W-1:0] SLOT_NUM = FRM_W'(SLOT_FRAME);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             manual_v, auto_v;

  assign hit_o = frm_start && (frm_num == SLOT_NUM);

  // next-state: single-shot request flag
  always_comb begin
    if (!single_i) begin
      pend_d = 1'b0;
    end else begin
      pend_d = (pend_q & ~hit_o) | shot_i;
    end
  end

  // next-state: queued automatic error reports, saturating
  always_comb begin
    cnt_d = cnt_q;
    if (!auto_i) begin
      cnt_d = '0;
    end else begin
      if (hit_o && (cnt_d != '0)) begin
        cnt_d = cnt_d - CNT_W'(1);
      end
      if (err_i && (cnt_d != CNT_MAX)) begin
        cnt_d = cnt_d + CNT_W'(1);
      end
    end
  end

  always_comb begin
    manual_v = single_i ? ~pend_q : static_i;
    auto_v   = ~(auto_i && (cnt_q != '0));
    e_o      = manual_v & auto_v & ~hold_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/e1nf_sa_sel.sv
module e1nf_sa_sel
  import e1nf_pkg::*;
(
  input  sa_mode_e        mode_i,
  input  logic [SA_W-1:0] reg_i,
  input  logic            ext_i,
  input  logic            hdlc_i,
  input  logic [SA_W-1:0] stack_i,
  output logic [SA_W-1:0] sa_o
);

  always_comb begin
    unique case (mode_i)
      SA_EXT:   sa_o = {reg_i[SA_W-1:1], ext_i};
      SA_HDLC:  sa_o = {reg_i[SA_W-1:1], hdlc_i};
      SA_STACK: sa_o = stack_i;
      default:  sa_o = reg_i;
    endcase
  end

endmodule

// File: rtl/e1nf_composer.sv
module e1nf_composer
  import e1nf_pkg::*;
#(
  parameter int unsigned E_CNT_W   = 2,
  parameter int unsigned E_FRAME_A = 13,
  parameter int unsigned E_FRAME_B = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_start,
  input  logic [FRM_W-1:0]   frm_num,
  input  logic               rx_lfa,
  input  logic               rx_lmfa,
  input  logic               rx_lmfa_timed,
  input  logic               rx_lsmfa,
  input  logic               rx_sa6_8h,
  input  logic               rx_sa6_ch,
  input  logic               rx_smf_err,
  input  logic               rx_smf_id,
  input  logic               cfg_a_force,
  input  logic [N_ACOND-1:0] cfg_a_en,
  input  logic               cfg_e_single,
  input  logic               cfg_e13_val,
  input  logic               cfg_e15_val,
  input  logic               sw_e13_clr,
  input  logic               sw_e15_clr,
  input  logic               cfg_e_auto,
  input  logic               cfg_e_lmfa_hold,
  input  logic               cfg_e_timed_hold,
  input  logic [1:0]         cfg_sa_mode,
  input  logic [SA_W-1:0]    cfg_sa_reg,
  input  logic               ext_dl,
  input  logic               hdlc_dl,
  input  logic [SA_W-1:0]    stack_word,
  output logic               tx_e_bit,
  output logic               tx_a_bit,
  output logic [SA_W-1:0]    tx_sa
);

  localparam cfg_t CFG_RST = '{
    a_force:    1'b0,
    a_en:       '0,
    e_single:   1'b0,
    e_static:   '1,
    e_auto:     1'b0,
    e_hold:     1'b0,
    e_hold_tmr: 1'b0,
    sa_mode:    SA_REG,
    sa_reg:     '1
  };

  // frame events
  logic mf_load, nfas_go;
  assign mf_load = frm_start && (frm_num == '0);
  assign nfas_go = frm_start && frm_num[0];

  // shadow configuration, loaded at the multiframe boundary
  cfg_t cfg_live, cfg_q, cfg_d;

  always_comb begin
    cfg_live.a_force    = cfg_a_force;
    cfg_live.a_en       = cfg_a_en;
    cfg_live.e_single   = cfg_e_single;
    cfg_live.e_static   = {cfg_e15_val, cfg_e13_val};
    cfg_live.e_auto     = cfg_e_auto;
    cfg_live.e_hold     = cfg_e_lmfa_hold;
    cfg_live.e_hold_tmr = cfg_e_timed_hold;
    cfg_live.sa_mode    = sa_mode_e'(cfg_sa_mode);
    cfg_live.sa_reg     = cfg_sa_reg;
    cfg_d = mf_load ? cfg_live : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // A bit
  logic [N_ACOND-1:0] cond_v;
  logic               a_val;

  always_comb begin
    cond_v              = '0;
    cond_v[AC_LFA]      = rx_lfa;
    cond_v[AC_LMFA]     = rx_lmfa;
    cond_v[AC_LSMFA]    = rx_lsmfa;
    cond_v[AC_LMFA_TMR] = rx_lmfa_timed;
    cond_v[AC_SA6_8]    = rx_sa6_8h;
    cond_v[AC_SA6_C]    = rx_sa6_ch;
  end

  e1nf_alarm u_alarm (
    .force_i (cfg_q.a_force),
    .en_i    (cfg_q.a_en),
    .cond_i  (cond_v),
    .a_o     (a_val)
  );

  // E bits, one slot per reporting frame
  logic                hold_v;
  logic [N_ESLOT-1:0]  shot_v, slot_hit, slot_e;

  assign hold_v = (cfg_q.e_hold & rx_lmfa) | (cfg_q.e_hold_tmr & rx_lmfa_timed);
  assign shot_v = {sw_e15_clr, sw_e13_clr};

  for (genvar s = 0; s < N_ESLOT; s++) begin : g_eslot
    localparam int unsigned FRAME_S = (s == 0) ? E_FRAME_A : E_FRAME_B;
    logic err_s;
    assign err_s = rx_smf_err && (rx_smf_id == (s != 0));

    e1nf_eslot #(
      .CNT_W      (E_CNT_W),
      .SLOT_FRAME (FRAME_S)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_start (frm_start),
      .frm_num   (frm_num),
      .single_i  (cfg_q.e_single),
      .static_i  (cfg_q.e_static[s]),
      .auto_i    (cfg_q.e_auto),
      .hold_i    (hold_v),
      .shot_i    (shot_v[s]),
      .err_i     (err_s),
      .hit_o     (slot_hit[s]),
      .e_o       (slot_e[s])
    );
  end

  // Sa bits
  logic [SA_W-1:0] sa_val;

  e1nf_sa_sel u_sa (
    .mode_i  (cfg_q.sa_mode),
    .reg_i   (cfg_q.sa_reg),
    .ext_i   (ext_dl),
    .hdlc_i  (hdlc_dl),
    .stack_i (stack_word),
    .sa_o    (sa_val)
  );

  // output registers
  logic            e_d;
  logic            a_d;
  logic [SA_W-1:0] sa_d;

  always_comb begin
    e_d  = tx_e_bit;
    a_d  = tx_a_bit;
    sa_d = tx_sa;
    if (nfas_go) begin
      e_d = 1'b1;
      for (int s = 0; s < N_ESLOT; s++) begin
        if (slot_hit[s]) begin
          e_d = slot_e[s];
        end
      end
      a_d  = a_val;
      sa_d = sa_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_e_bit <= 1'b1;
      tx_a_bit <= 1'b0;
      tx_sa    <= '1;
    end else begin
      tx_e_bit <= e_d;
      tx_a_bit <= a_d;
      tx_sa    <= sa_d;
    end
  end

endmodule

// File: rtl/e1nf_composer_chk.sv
module e1nf_composer_chk
  import e1nf_pkg::*;
#(
  parameter int unsigned E_FRAME_A = 13,
  parameter int unsigned E_FRAME_B = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frm_start,
  input logic [FRM_W-1:0] frm_num,
  input logic            rx_lmfa,
  input cfg_t            cfg_q,
  input logic            tx_e_bit,
  input logic            tx_a_bit,
  input logic [SA_W-1:0] tx_sa
);

  localparam logic [FRM_W-1:0] FA = FRM_W'(E_FRAME_A);
  localparam logic [FRM_W-1:0] FB = FRM_W'(E_FRAME_B);

  logic odd_start, eslot_start;
  assign odd_start   = frm_start && frm_num[0];
  assign eslot_start = frm_start && ((frm_num == FA) || (frm_num == FB));

  assert_outputs_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !odd_start |=> $stable({tx_e_bit, tx_a_bit, tx_sa}));

  assert_force_alarm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_start && cfg_q.a_force) |=> tx_a_bit);

  assert_e_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_start && !eslot_start) |=> tx_e_bit);

  assert_lmfa_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eslot_start && cfg_q.e_hold && rx_lmfa) |=> !tx_e_bit);

  assert_sa_register_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_start && (cfg_q.sa_mode == SA_REG)) |=> (tx_sa == $past(cfg_q.sa_reg)));

endmodule

bind e1nf_composer e1nf_composer_chk #(
  .E_FRAME_A (E_FRAME_A),
  .E_FRAME_B (E_FRAME_B)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_start (frm_start),
  .frm_num   (frm_num),
  .rx_lmfa   (rx_lmfa),
  .cfg_q     (cfg_q),
  .tx_e_bit  (tx_e_bit),
  .tx_a_bit  (tx_a_bit),
  .tx_sa     (tx_sa)
);

// File: tb/e1nf_composer_bench.sv
module e1nf_composer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk;
  logic       rst_n;
  logic       frm_start;
  logic [3:0] frm_num;
  logic [5:0] cond_v;
  logic       rx_smf_err, rx_smf_id;
  logic       cfg_a_force;
  logic [5:0] cfg_a_en;
  logic       cfg_e_single, cfg_e13_val, cfg_e15_val;
  logic       sw_e13_clr, sw_e15_clr;
  logic       cfg_e_auto, cfg_e_lmfa_hold, cfg_e_timed_hold;
  logic [1:0] cfg_sa_mode;
  logic [4:0] cfg_sa_reg;
  logic       ext_dl, hdlc_dl;
  logic [4:0] stack_word;
  logic       tx_e_bit, tx_a_bit;
  logic [4:0] tx_sa;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int obs_e [16];
  int obs_a [16];
  int obs_sa[16];

  e1nf_composer u_e1nf_composer (
    .clk (clk), .rst_n (rst_n), .frm_start (frm_start), .frm_num (frm_num),
    .rx_lfa (cond_v[0]), .rx_lmfa (cond_v[1]), .rx_lmfa_timed (cond_v[3]),
    .rx_lsmfa (cond_v[2]), .rx_sa6_8h (cond_v[4]), .rx_sa6_ch (cond_v[5]),
    .rx_smf_err (rx_smf_err), .rx_smf_id (rx_smf_id),
    .cfg_a_force (cfg_a_force), .cfg_a_en (cfg_a_en),
    .cfg_e_single (cfg_e_single), .cfg_e13_val (cfg_e13_val), .cfg_e15_val (cfg_e15_val),
    .sw_e13_clr (sw_e13_clr), .sw_e15_clr (sw_e15_clr),
    .cfg_e_auto (cfg_e_auto), .cfg_e_lmfa_hold (cfg_e_lmfa_hold),
    .cfg_e_timed_hold (cfg_e_timed_hold),
    .cfg_sa_mode (cfg_sa_mode), .cfg_sa_reg (cfg_sa_reg),
    .ext_dl (ext_dl), .hdlc_dl (hdlc_dl), .stack_word (stack_word),
    .tx_e_bit (tx_e_bit), .tx_a_bit (tx_a_bit), .tx_sa (tx_sa)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    frm_num   = 4'(n);
    frm_start = 1'b1;
    @(negedge clk);
    frm_start = 1'b0;
    obs_e[n]  = int'(tx_e_bit);
    obs_a[n]  = int'(tx_a_bit);
    obs_sa[n] = int'(tx_sa);
  endtask

  task automatic run_mf();
    for (int n = 0; n < 16; n++) tick(n);
  endtask

  task automatic pulse_shot(input bit slot15);
    @(negedge clk);
    if (slot15) sw_e15_clr = 1'b1; else sw_e13_clr = 1'b1;
    @(negedge clk);
    sw_e13_clr = 1'b0;
    sw_e15_clr = 1'b0;
  endtask

  task automatic pulse_err(input bit id);
    @(negedge clk);
    rx_smf_err = 1'b1;
    rx_smf_id  = id;
    @(negedge clk);
    rx_smf_err = 1'b0;
  endtask

  // checks all odd frames of the last multiframe
  task automatic check_mf(input string req, input int e13, input int e15,
                          input int a, input int sa);
    for (int n = 1; n < 16; n += 2) begin
      chk(req, $sformatf("E bit frame %0d", n), obs_e[n],
          (n == 13) ? e13 : ((n == 15) ? e15 : 1));
      chk(req, $sformatf("A bit frame %0d", n), obs_a[n], a);
      chk(req, $sformatf("Sa frame %0d", n), obs_sa[n], sa);
    end
  endtask

  task automatic t_reset();
    chk("R1", "reset E", int'(tx_e_bit), 1);
    chk("R1", "reset A", int'(tx_a_bit), 0);
    chk("R1", "reset Sa", int'(tx_sa), 31);
  endtask

  task automatic t_default();
    cfg_sa_reg = 5'b10110;
    run_mf();
    check_mf("R4", 1, 1, 0, 5'b10110);
    // even frame starts leave the outputs alone (R1)
    cfg_a_force = 1'b1;
    tick(0);
    cfg_a_force = 1'b0;
    tick(1);
    chk("R1", "A after frame 1", obs_a[1], 1);
    tick(2);
    chk("R1", "A held over frame 2", int'(tx_a_bit), 1);
    run_mf();
    check_mf("R2", 1, 1, 0, 5'b10110);
  endtask

  task automatic t_boundary();
    cfg_sa_reg = 5'b00011;
    run_mf();
    for (int n = 0; n < 6; n++) tick(n);
    cfg_sa_reg  = 5'b11000;
    cfg_a_force = 1'b1;
    cfg_e13_val = 1'b0;
    for (int n = 6; n < 16; n++) tick(n);
    for (int n = 7; n < 16; n += 2) begin
      chk("R12", $sformatf("Sa old frame %0d", n), obs_sa[n], 5'b00011);
      chk("R12", $sformatf("A old frame %0d", n), obs_a[n], 0);
    end
    chk("R12", "E13 old", obs_e[13], 1);
    run_mf();
    check_mf("R12", 0, 1, 1, 5'b11000);
    cfg_a_force = 1'b0;
    cfg_e13_val = 1'b1;
    run_mf();
    check_mf("R2", 1, 1, 0, 5'b11000);
  endtask

  task automatic t_alarm_conditions();
    for (int c = 0; c < 6; c++) begin
      cfg_a_en = 6'(1 << c);
      cond_v   = 6'(1 << c);
      run_mf();
      chk("R3", $sformatf("cond %0d enabled active", c), obs_a[5], 1);
      chk("R3", $sformatf("cond %0d enabled active f15", c), obs_a[15], 1);
      cond_v = ~6'(1 << c);
      run_mf();
      chk("R3", $sformatf("cond %0d enabled, others active", c), obs_a[5], 0);
    end
    cfg_a_en = '0;
    cond_v   = '1;
    run_mf();
    chk("R3", "all conditions, none enabled", obs_a[9], 0);
    cond_v = '0;
    run_mf();
  endtask

  task automatic t_static();
    cfg_e13_val = 1'b0;
    cfg_e15_val = 1'b1;
    run_mf();
    check_mf("R5", 0, 1, 0, 5'b11000);
    cfg_e13_val = 1'b1;
    cfg_e15_val = 1'b0;
    run_mf();
    check_mf("R5", 1, 0, 0, 5'b11000);
    cfg_e15_val = 1'b1;
    run_mf();
  endtask

  task automatic t_single();
    // pulses in static mode are discarded
    pulse_shot(1'b0);
    pulse_shot(1'b1);
    cfg_e_single = 1'b1;
    run_mf();
    check_mf("R6", 1, 1, 0, 5'b11000);
    pulse_shot(1'b0);
    run_mf();
    check_mf("R6", 0, 1, 0, 5'b11000);
    run_mf();
    check_mf("R6", 1, 1, 0, 5'b11000);
    pulse_shot(1'b1);
    run_mf();
    check_mf("R6", 1, 0, 0, 5'b11000);
    cfg_e_single = 1'b0;
    run_mf();
  endtask

  task automatic t_auto();
    cfg_e_auto = 1'b1;
    run_mf();
    pulse_err(1'b0);
    pulse_err(1'b0);
    pulse_err(1'b1);
    run_mf();
    check_mf("R7", 0, 0, 0, 5'b11000);
    run_mf();
    check_mf("R7", 0, 1, 0, 5'b11000);
    run_mf();
    check_mf("R7", 1, 1, 0, 5'b11000);
    // five reports on slot I: three queued, rest dropped
    for (int k = 0; k < 5; k++) pulse_err(1'b0);
    for (int m = 0; m < 3; m++) begin
      run_mf();
      chk("R7", $sformatf("queued report %0d", m), obs_e[13], 0);
    end
    run_mf();
    chk("R7", "queue drained after three", obs_e[13], 1);
    cfg_e_auto = 1'b0;
    run_mf();
  endtask

  task automatic t_hold();
    cfg_e_lmfa_hold = 1'b1;
    cond_v[1] = 1'b1;
    run_mf();
    check_mf("R8", 0, 0, 0, 5'b11000);
    cond_v[1] = 1'b0;
    run_mf();
    check_mf("R8", 1, 1, 0, 5'b11000);
    cfg_e_lmfa_hold = 1'b0;
    cond_v[1] = 1'b1;
    run_mf();
    check_mf("R8", 1, 1, 0, 5'b11000);
    cond_v[1] = 1'b0;
    cfg_e_timed_hold = 1'b1;
    cond_v[3] = 1'b1;
    run_mf();
    check_mf("R9", 0, 0, 0, 5'b11000);
    cond_v[3] = 1'b0;
    run_mf();
    check_mf("R9", 1, 1, 0, 5'b11000);
    cfg_e_timed_hold = 1'b0;
    run_mf();
  endtask

  task automatic t_combine();
    cfg_e_single = 1'b1;
    cfg_e_auto   = 1'b1;
    run_mf();
    pulse_shot(1'b0);
    pulse_err(1'b1);
    run_mf();
    check_mf("R10", 0, 0, 0, 5'b11000);
    run_mf();
    check_mf("R10", 1, 1, 0, 5'b11000);
    cfg_e_single = 1'b0;
    cfg_e_auto   = 1'b0;
    cfg_e15_val  = 1'b0;
    cfg_e_lmfa_hold = 1'b1;
    run_mf();
    check_mf("R10", 1, 0, 0, 5'b11000);
    cfg_e15_val = 1'b1;
    cfg_e_lmfa_hold = 1'b0;
    run_mf();
  endtask

  task automatic t_sa_modes();
    cfg_sa_reg  = 5'b10101;
    cfg_sa_mode = 2'd1;
    for (int n = 0; n < 16; n++) begin
      ext_dl  = (n % 3 == 0);
      hdlc_dl = !(n % 3 == 0);
      tick(n);
      if (n % 2 == 1)
        chk("R11", $sformatf("ext mode frame %0d", n), obs_sa[n], 5'b10100 | int'(n % 3 == 0));
    end
    cfg_sa_mode = 2'd2;
    for (int n = 0; n < 16; n++) begin
      hdlc_dl = (n % 5 == 1);
      ext_dl  = !(n % 5 == 1);
      tick(n);
      if (n % 2 == 1)
        chk("R11", $sformatf("hdlc mode frame %0d", n), obs_sa[n], 5'b10100 | int'(n % 5 == 1));
    end
    cfg_sa_mode = 2'd3;
    for (int n = 0; n < 16; n++) begin
      stack_word = 5'(n + 3);
      tick(n);
      if (n % 2 == 1)
        chk("R11", $sformatf("stack mode frame %0d", n), obs_sa[n], (n + 3) % 32);
    end
    cfg_sa_mode = 2'd0;
    run_mf();
    check_mf("R11", 1, 1, 0, 5'b10101);
  endtask

  initial begin
    rst_n = 1'b0; frm_start = 1'b0; frm_num = '0; cond_v = '0;
    rx_smf_err = 1'b0; rx_smf_id = 1'b0;
    cfg_a_force = 1'b0; cfg_a_en = '0;
    cfg_e_single = 1'b0; cfg_e13_val = 1'b1; cfg_e15_val = 1'b1;
    sw_e13_clr = 1'b0; sw_e15_clr = 1'b0;
    cfg_e_auto = 1'b0; cfg_e_lmfa_hold = 1'b0; cfg_e_timed_hold = 1'b0;
    cfg_sa_mode = '0; cfg_sa_reg = '1;
    ext_dl = 1'b0; hdlc_dl = 1'b0; stack_word = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_boundary();
    t_alarm_conditions();
    t_static();
    t_single();
    t_auto();
    t_hold();
    t_combine();
    t_sa_modes();
    finish_run();
  end

endmodule